// File: doc/BRIEF.md
# Age-Ordered Result Broadcast Arbiter

Several producers of results share one result broadcast bus: six memory-load buffers, two multiply stations and three add stations. Any number of them can request the bus in a cycle. Each request comes with a small issue-order sequence number and a result word. In every cycle the arbiter grants the bus to the request whose operation was issued earliest. It answers the winning producer with a combinational one-hot grant in the same cycle.

In the next cycle the winner's result word and its 4-bit producer tag appear on registered bus outputs, together with a valid strobe. Every listener samples them in that cycle. The tag identifies the producer and also its class. Load buffers take tags 1 to 6, multiply stations take 8 and 9, and add stations take 10 to 12. Tag 0 means "value already present" to the listeners, so it is never broadcast as a producer tag. A producer that is not granted holds its request, sequence number and data unchanged until it is granted.

Top module: `rbus_result_arbiter`

## Requirements
- R1: Request ports 0 to 5 are load buffers. When port p wins, the broadcast tag is p+1, so the tags run from 1 to 6.
- R2: Ports 6 and 7 are multiply stations and broadcast tags 8 and 9. Ports 8, 9 and 10 are add stations and broadcast tags 10, 11 and 12.
- R3: Among the requesting ports, the grant goes to the one with the oldest sequence number. When two sequence numbers are equal, the lower port number wins.
- R4: Sequence numbers are 6 bits wide and are compared modulo 64. Value a is older than b when (a - b) mod 64 is 32 or more. Ordering therefore stays correct across counter roll-over, provided that the live requests span fewer than 32 issues.
- R5: grant_o is one-hot over the requesting ports whenever at least one request is raised. It is all zero when no request is raised.
- R6: In the cycle after a grant, bus_valid_o is 1 and bus_tag_o and bus_data_o carry the granted port's tag and data.
- R7: In the cycle after a cycle with no request, bus_valid_o is 0 and bus_tag_o and bus_data_o are 0.
- R8: bus_tag_o is never 0 while bus_valid_o is 1.
- R9: A synchronous active-high reset clears bus_valid_o, bus_tag_o and bus_data_o in the following cycle, whatever requests are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 11 | Request per port (0-5 load, 6-7 multiply, 8-10 add) |
| req_seq_i | input | 66 | Issue sequence number per port, port p at bits [6p+5:6p] |
| req_data_i | input | 352 | Result word per port, port p at bits [32p+31:32p] |
| grant_o | output | 11 | One-hot grant, same cycle as the request |
| bus_valid_o | output | 1 | Broadcast valid strobe, registered |
| bus_tag_o | output | 4 | Producer tag of the broadcast value, registered |
| bus_data_o | output | 32 | Broadcast result word, registered |

## Verification
Two cases are hard to reach from the ports. The first is a comparison across sequence-number roll-over, where the numerically smaller value is the newer one. The second is an exact tie between two ports. Random traffic seldom produces either at a moment when both requests are live together. The stimulus therefore places them directly: it sets the issue counter just below 64 so that one request lands before the wrap and one after it, and it issues two requests with the same number on non-adjacent ports. A long random phase follows. Its request rates vary, so it covers idle cycles, all ports busy at once, and many natural wraps of the counter.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

  // True when sequence number a was issued before b, modulo 2**w.
  function automatic logic seq_older(input logic [15:0] a, input logic [15:0] b, input int w);
    logic [15:0] diff;
    diff = a - b;
    return diff[w-1];
  endfunction

endpackage

// File: rtl/rbus_age_node.sv
module rbus_age_node #(
  parameter int SEQ_W = 6,
  parameter int IDX_W = 4
) (
  input  logic             a_v,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_v,
  input  logic [SEQ_W-1:0] b_seq,
  input  logic [IDX_W-1:0] b_idx,
  output logic             o_v,
  output logic [SEQ_W-1:0] o_seq,
  output logic [IDX_W-1:0] o_idx
);

  logic [SEQ_W-1:0] diff;
  logic             b_first;

  // b beats a only when strictly older; a (lower index side) keeps ties
  always_comb begin
    diff    = b_seq - a_seq;
    b_first = b_v && (!a_v || diff[SEQ_W-1]);
    o_v     = a_v || b_v;
    o_seq   = b_first ? b_seq : a_seq;
    o_idx   = b_first ? b_idx : a_idx;
  end

endmodule

// File: rtl/rbus_age_tree.sv
module rbus_age_tree #(
  parameter int N_PORT = 11,
  parameter int SEQ_W  = 6,
  parameter int IDX_W  = 4
) (
  input  logic [N_PORT-1:0]       req_v,
  input  logic [N_PORT*SEQ_W-1:0] req_seq,
  output logic                    win_v,
  output logic [IDX_W-1:0]        win_idx
);

  localparam int N_LEAF = 1 << IDX_W;

  // heap layout: node k fed by 2k and 2k+1, leaves at N_LEAF..2*N_LEAF-1
  logic             nv   [2*N_LEAF];
  logic [SEQ_W-1:0] nseq [2*N_LEAF];
  logic [IDX_W-1:0] nidx [2*N_LEAF];

  assign nv[0]   = 1'b0;
  assign nseq[0] = '0;
  assign nidx[0] = '0;

  for (genvar i = 0; i < N_LEAF; i++) begin : g_leaf
    if (i < N_PORT) begin : g_used
      assign nv[N_LEAF+i]   = req_v[i];
      assign nseq[N_LEAF+i] = req_seq[i*SEQ_W +: SEQ_W];
    end else begin : g_pad
      assign nv[N_LEAF+i]   = 1'b0;
      assign nseq[N_LEAF+i] = '0;
    end
    assign nidx[N_LEAF+i] = IDX_W'(i);
  end

  for (genvar k = 1; k < N_LEAF; k++) begin : g_node
    rbus_age_node #(.SEQ_W(SEQ_W), .IDX_W(IDX_W)) node_i (
      .a_v   (nv[2*k]),
      .a_seq (nseq[2*k]),
      .a_idx (nidx[2*k]),
      .b_v   (nv[2*k+1]),
      .b_seq (nseq[2*k+1]),
      .b_idx (nidx[2*k+1]),
      .o_v   (nv[k]),
      .o_seq (nseq[k]),
      .o_idx (nidx[k])
    );
  end

  assign win_v   = nv[1];
  assign win_idx = nidx[1];

endmodule

// File: rtl/rbus_tag_map.sv
module rbus_tag_map #(
  parameter int N_LOAD    = 6,
  parameter int N_MUL     = 2,
  parameter int N_ADD     = 3,
  parameter int TAG_W     = 4,
  parameter int IDX_W     = 4,
  parameter int LOAD_TAG0 = 1,
  parameter int MUL_TAG0  = 8,
  parameter int ADD_TAG0  = 10
) (
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  localparam int N_PORT = N_LOAD + N_MUL + N_ADD;
  localparam int N_LEAF = 1 << IDX_W;

  logic [TAG_W-1:0] lut [N_LEAF];

  for (genvar p = 0; p < N_LEAF; p++) begin : g_lut
    if (p < N_LOAD) begin : g_load
      assign lut[p] = TAG_W'(LOAD_TAG0 + p);
    end else if (p < N_LOAD + N_MUL) begin : g_mul
      assign lut[p] = TAG_W'(MUL_TAG0 + p - N_LOAD);
    end else if (p < N_PORT) begin : g_add
      assign lut[p] = TAG_W'(ADD_TAG0 + p - N_LOAD - N_MUL);
    end else begin : g_none
      assign lut[p] = '0;
    end
  end

  assign tag = lut[idx];

endmodule

// File: rtl/rbus_result_arbiter.sv
module rbus_result_arbiter #(
  parameter int N_LOAD    = 6,
  parameter int N_MUL     = 2,
  parameter int N_ADD     = 3,
  parameter int DATA_W    = 32,
  parameter int SEQ_W     = 6,
  parameter int TAG_W     = 4,
  parameter int LOAD_TAG0 = 1,
  parameter int MUL_TAG0  = 8,
  parameter int ADD_TAG0  = 10
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [N_LOAD+N_MUL+N_ADD-1:0]          req_valid_i,
  input  logic [(N_LOAD+N_MUL+N_ADD)*SEQ_W-1:0]  req_seq_i,
  input  logic [(N_LOAD+N_MUL+N_ADD)*DATA_W-1:0] req_data_i,
  output logic [N_LOAD+N_MUL+N_ADD-1:0]          grant_o,
  output logic                                   bus_valid_o,
  output logic [TAG_W-1:0]                       bus_tag_o,
  output logic [DATA_W-1:0]                      bus_data_o
);

  localparam int N_PORT = N_LOAD + N_MUL + N_ADD;
  localparam int IDX_W  = (N_PORT > 1) ? $clog2(N_PORT) : 1;
  localparam int N_LEAF = 1 << IDX_W;

  logic              win_v;
  logic [IDX_W-1:0]  win_idx;
  logic [TAG_W-1:0]  win_tag;
  logic [DATA_W-1:0] data_arr [N_LEAF];
  logic [DATA_W-1:0] win_data;

  rbus_age_tree #(.N_PORT(N_PORT), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) tree_i (
    .req_v   (req_valid_i),
    .req_seq (req_seq_i),
    .win_v   (win_v),
    .win_idx (win_idx)
  );

  rbus_tag_map #(
    .N_LOAD(N_LOAD), .N_MUL(N_MUL), .N_ADD(N_ADD), .TAG_W(TAG_W), .IDX_W(IDX_W),
    .LOAD_TAG0(LOAD_TAG0), .MUL_TAG0(MUL_TAG0), .ADD_TAG0(ADD_TAG0)
  ) tag_i (
    .idx (win_idx),
    .tag (win_tag)
  );

  for (genvar p = 0; p < N_LEAF; p++) begin : g_port
    if (p < N_PORT) begin : g_used
      assign data_arr[p] = req_data_i[p*DATA_W +: DATA_W];
      assign grant_o[p]  = win_v && (win_idx == IDX_W'(p));
    end else begin : g_pad
      assign data_arr[p] = '0;
    end
  end

  assign win_data = data_arr[win_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid_o <= 1'b0;
      bus_tag_o   <= '0;
      bus_data_o  <= '0;
    end else begin
      bus_valid_o <= win_v;
      bus_tag_o   <= win_v ? win_tag : '0;
      bus_data_o  <= win_v ? win_data : '0;
    end
  end

endmodule

// File: rtl/rbus_result_arbiter_chk.sv
module rbus_result_arbiter_chk #(
  parameter int N_PORT = 11,
  parameter int SEQ_W  = 6,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [N_PORT-1:0]       req_valid_i,
  input logic [N_PORT*SEQ_W-1:0] req_seq_i,
  input logic [N_PORT-1:0]       grant_o,
  input logic                    bus_valid_o,
  input logic [TAG_W-1:0]        bus_tag_o,
  input logic [DATA_W-1:0]       bus_data_o
);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  // R5
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o & ~req_valid_i) == '0);

  // R5
  grant_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_valid_i) |-> (|grant_o));

  // R6
  bus_follows_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |=> bus_valid_o);

  // R7
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid_o |-> (bus_tag_o == '0 && bus_data_o == '0));

  // R8
  tag_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> (bus_tag_o != '0));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !bus_valid_o);

  // R3 R4: no other live request is strictly older than the granted one
  for (genvar i = 0; i < N_PORT; i++) begin : g_win
    for (genvar j = 0; j < N_PORT; j++) begin : g_other
      if (i != j) begin : g_pair
        // R3
        age_order_chk: assert property (@(posedge clk) disable iff (rst)
          (grant_o[i] && req_valid_i[j]) |->
            !rbus_pkg::seq_older(16'(req_seq_i[j*SEQ_W +: SEQ_W]),
                                 16'(req_seq_i[i*SEQ_W +: SEQ_W]), SEQ_W) &&
            !(j < i && req_seq_i[j*SEQ_W +: SEQ_W] == req_seq_i[i*SEQ_W +: SEQ_W]));
      end
    end
  end

endmodule

bind rbus_result_arbiter rbus_result_arbiter_chk #(
  .N_PORT(N_LOAD + N_MUL + N_ADD), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_seq_i   (req_seq_i),
  .grant_o     (grant_o),
  .bus_valid_o (bus_valid_o),
  .bus_tag_o   (bus_tag_o),
  .bus_data_o  (bus_data_o)
);

// File: tb/rbus_result_arbiter_tb_top.sv
module rbus_result_arbiter_tb_top;

  localparam int NP = 11;
  localparam int SW = 6;
  localparam int DW = 32;
  localparam int TW = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    req_valid_i = '0;
  logic [NP*SW-1:0] req_seq_i = '0;
  logic [NP*DW-1:0] req_data_i = '0;
  logic [NP-1:0]    grant_o;
  logic             bus_valid_o;
  logic [TW-1:0]    bus_tag_o;
  logic [DW-1:0]    bus_data_o;

  always #10 clk = ~clk;

  rbus_result_arbiter dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_seq_i(req_seq_i),
    .req_data_i(req_data_i), .grant_o(grant_o), .bus_valid_o(bus_valid_o),
    .bus_tag_o(bus_tag_o), .bus_data_o(bus_data_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model: unbounded issue numbers, smallest number is oldest
  longint     issue_ctr = 0;
  bit         pend_v   [NP];
  longint     pend_iss [NP];
  logic [31:0] pend_dat [NP];
  bit          exp_bv = 0;
  int          exp_port = -1;
  logic [3:0]  exp_tag = 0;
  logic [31:0] exp_dat = 0;

  // R1 R2: port to tag as stated in the requirements
  function automatic int tag_of(input int p);
    if (p < 6) return p + 1;
    if (p < 8) return p + 2;
    return p + 2;
  endfunction

  task automatic add_req(input int p);
    pend_v[p]   = 1;
    pend_iss[p] = issue_ctr;
    pend_dat[p] = $urandom();
    issue_ctr   = issue_ctr + 1;
  endtask

  task automatic check_bus();
    string rq;
    n_chk++;
    if (!exp_bv) rq = "R7";
    else if (exp_port < 6) rq = "R1 R6";
    else rq = "R2 R6";
    if (bus_valid_o !== exp_bv || bus_tag_o !== exp_tag || bus_data_o !== exp_dat) begin
      n_bad++;
      $display("FAIL %s bus: got v=%0d tag=%0d data=%h exp v=%0d tag=%0d data=%h",
               rq, bus_valid_o, bus_tag_o, bus_data_o, exp_bv, exp_tag, exp_dat);
    end
    if (bus_valid_o === 1'b1) begin
      n_chk++;
      if (bus_tag_o === 4'd0) begin // R8
        n_bad++;
        $display("FAIL R8 tag zero while valid: got %0d exp nonzero", bus_tag_o);
      end
    end
  endtask

  // one cycle: check registered bus, drive requests, check grant, update model
  task automatic cycle(input string rq);
    int w;
    logic [NP-1:0] eg;
    @(negedge clk);
    check_bus();
    for (int p = 0; p < NP; p++) begin
      req_valid_i[p] = pend_v[p];
      req_seq_i[p*SW +: SW] = pend_v[p] ? SW'(pend_iss[p]) : '0;
      req_data_i[p*DW +: DW] = pend_v[p] ? pend_dat[p] : 32'hDEAD_0000 + 32'(p);
    end
    #1;
    w = -1;
    for (int p = 0; p < NP; p++)
      if (pend_v[p] && (w < 0 || pend_iss[p] < pend_iss[w])) w = p;
    eg = (w < 0) ? '0 : (NP'(1) << w);
    n_chk++;
    if (grant_o !== eg) begin
      n_bad++;
      $display("FAIL %s grant: got %b exp %b", (w < 0) ? "R5" : rq, grant_o, eg);
    end
    exp_bv   = (w >= 0);
    exp_port = w;
    exp_tag  = (w >= 0) ? 4'(tag_of(w)) : 4'd0;
    exp_dat  = (w >= 0) ? pend_dat[w] : 32'd0;
    if (w >= 0) pend_v[w] = 0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) pend_v[p] = 0;
    // R9: reset held with every port requesting
    rst = 1'b1;
    req_valid_i = '1;
    req_data_i = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (bus_valid_o !== 1'b0 || bus_tag_o !== 4'd0 || bus_data_o !== 32'd0) begin
      n_bad++;
      $display("FAIL R9 reset: got v=%0d tag=%0d data=%h exp 0 0 0", bus_valid_o, bus_tag_o, bus_data_o);
    end
    req_valid_i = '0;
    rst = 1'b0;

    // R1 R2: each port alone
    for (int p = 0; p < NP; p++) begin
      add_req(p);
      cycle("R1 R2");
    end
    cycle("R7");
    cycle("R7");

    // R3: tie on equal sequence number, lower port wins
    add_req(9);
    pend_iss[2] = pend_iss[9]; pend_v[2] = 1; pend_dat[2] = 32'h1234_5678;
    cycle("R3");
    cycle("R3");
    cycle("R7");

    // R4: wrap, 62 is older than 1 (issue 65)
    issue_ctr = 62;
    add_req(7);
    issue_ctr = 65;
    add_req(1);
    cycle("R4");
    cycle("R4");
    cycle("R7");

    // R3: all ports at once, issued from high port to low
    for (int p = NP - 1; p >= 0; p--) add_req(p);
    for (int k = 0; k < NP; k++) cycle("R3");
    cycle("R7");

    // random traffic with varying rate; counter wraps many times
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 500; c++) begin
        for (int p = 0; p < NP; p++)
          if (!pend_v[p] && ($urandom_range(99) < 8 * ph + 3)) add_req(p);
        cycle("R3 R4");
      end
    end
    for (int k = 0; k < NP + 2; k++) cycle("R3");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule